// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of an external parallel flash device. After software or another controller has issued a program or erase command sequence, the poller is started with the polled address. It then decides when the flash device's internal operation has finished, using only plain status reads. Bit 6 of a status read inverts on every read while the device is busy and stays put once it is idle. Bit 5 is the device's error flag.

The poller issues reads over a request/acknowledge interface. The first read only records a reference value for bit 6. Every later read compares its bit 6 against the value recorded by the read before it. When bit 5 is set on a read where bit 6 still toggled, the poller makes one extra confirming read. Bit 6 may have settled in the same instant that bit 5 rose, so this read decides between pass and error.

A loaded poll limit stops a device that never settles. For program operations, an optional final read compares the stored byte with the intended byte. Each run ends with a one-cycle done pulse and exactly one result flag.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no start, busy_o, done_o, rd_req_o and all four result flags are 0.
- R2: A start_i seen while idle latches the address, expected byte, mode, verify enable and poll limit, and raises busy_o. Every read of the run presents the latched address on rd_addr_o. rd_req_o is high only while busy_o is high. A read completes in a cycle with rd_req_o and rd_ack_i both high. The first read only captures bit 6 as a reference and never ends the run.
- R3: A read whose bit 6 equals bit 6 of the previous read ends polling as complete. Bit 5 is not consulted on such a read. For an erase run (erase_i=1), or when verify_en_i=0, the run then ends as pass.
- R4: A read whose bit 6 differs from the previous read, with bit 5 = 0 and the poll limit not reached, starts another read. The new bit 6 becomes the reference for the next comparison.
- R5: A read whose bit 6 toggled while bit 5 = 1 causes exactly one extra read. If bit 6 of that read equals bit 6 of the error read, polling is complete (followed by R7 when it applies).
- R6: If the extra read of R5 still shows bit 6 toggled, the run ends with fail_error_o.
- R7: For a program run (erase_i=0) with verify_en_i=1, completion triggers one more read of the same address. The run ends as pass if all 8 bits equal the expected byte, and with fail_verify_o otherwise.
- R8: An erase run, or a program run with verify_en_i=0, performs no verify read. Its read count is the polling reads only.
- R9: Comparing reads that toggle with bit 5 = 0 are counted from 1 per run. The one whose count reaches max_polls_i ends the run with fail_watchdog_o; a limit of 0 acts like 1. Bit 5 = 1 takes the R5 path before the limit is tested.
- R10: done_o is high for exactly one cycle, the cycle after the acknowledge of the deciding read. busy_o is low in that cycle and exactly one result flag is high. The flags keep their values until the next accepted start clears them.
- R11: start_i while busy_o is high is ignored: the latched address, the read count and the result of the run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a poll run (accepted only while idle) |
| addr_i | input | ADDR_W | Address to poll |
| exp_data_i | input | 8 | Byte intended to be programmed |
| erase_i | input | 1 | 1 = erase run, 0 = program run |
| verify_en_i | input | 1 | Enable final read-back compare on program runs |
| max_polls_i | input | CNT_W | Limit of toggling comparing reads |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i valid |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run passed |
| fail_error_o | output | 1 | Device error flag confirmed |
| fail_verify_o | output | 1 | Read-back byte mismatched |
| fail_watchdog_o | output | 1 | Poll limit reached |

## Verification
The hardest situation to reach from the ports is the confirming read after the error flag. Bit 5 must appear on a read where bit 6 still flipped, and the next read must either hold or flip bit 6 again. The bench's read responder plays back a scripted byte sequence per run, so these cases come from exact sequences. One sequence has bit 6 settling at the error read. Another has bit 6 flipping once more. A third chains the confirmation into a verify read. Read counts are checked alongside the result to show that exactly one extra read took place.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;
  localparam int DATA_W  = 8;
  localparam int TOG_BIT = 6;
  localparam int ERR_BIT = 5;
  localparam int RES_N   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_POLL,
    ST_RECHK,
    ST_VERIFY
  } tp_state_e;

  // one-hot result positions
  localparam int RES_PASS = 0;
  localparam int RES_ERR  = 1;
  localparam int RES_VER  = 2;
  localparam int RES_WDG  = 3;
endpackage

// File: rtl/tpoll_toggle.sv
module tpoll_toggle
  import tpoll_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int BIT = TOG_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic          toggled_o
);
  logic ref_q, ref_d;

  always_comb begin
    ref_d = ref_q;
    if (cap_i) ref_d = data_i[BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign toggled_o = data_i[BIT] ^ ref_q;
endmodule

// File: rtl/tpoll_wdog.sv
module tpoll_wdog #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] lim_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign last_o = (cnt_nx >= {1'b0, lim_i});

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_nx[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= lim_i) || (lim_i == '0 && cnt_q == '0));
endmodule

// File: rtl/tpoll_seq.sv
module tpoll_seq
  import tpoll_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic              erase_i,
  input  logic              ver_i,
  input  logic [CW-1:0]     max_i,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              toggled_i,
  input  logic              wd_last_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_N-1:0]  res_o,
  output logic              cap_o,
  output logic              wd_clr_o,
  output logic              wd_inc_o,
  output logic [CW-1:0]     wd_lim_o
);
  tp_state_e         st_q, st_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DATA_W-1:0] exp_q, exp_d;
  logic              erase_q, erase_d, ver_q, ver_d;
  logic [CW-1:0]     lim_q, lim_d;
  logic              done_q, done_d;
  logic [RES_N-1:0]  res_q, res_d;
  logic              accept;

  assign accept = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    exp_d    = exp_q;
    erase_d  = erase_q;
    ver_d    = ver_q;
    lim_d    = lim_q;
    done_d   = 1'b0;
    res_d    = res_q;
    cap_o    = 1'b0;
    wd_inc_o = 1'b0;
    wd_clr_o = accept;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_REF;
          addr_d  = addr_i;
          exp_d   = exp_i;
          erase_d = erase_i;
          ver_d   = ver_i;
          lim_d   = max_i;
          res_d   = '0;
        end
      end
      ST_REF: begin
        if (rd_ack_i) begin
          cap_o = 1'b1;
          st_d  = ST_POLL;
        end
      end
      ST_POLL: begin
        if (rd_ack_i) begin
          if (!toggled_i) begin
            if (!erase_q && ver_q) begin
              st_d = ST_VERIFY;
            end else begin
              st_d = ST_IDLE; done_d = 1'b1; res_d[RES_PASS] = 1'b1;
            end
          end else if (rd_data_i[ERR_BIT]) begin
            cap_o = 1'b1;
            st_d  = ST_RECHK;
          end else if (wd_last_i) begin
            st_d = ST_IDLE; done_d = 1'b1; res_d[RES_WDG] = 1'b1;
          end else begin
            cap_o    = 1'b1;
            wd_inc_o = 1'b1;
          end
        end
      end
      ST_RECHK: begin
        if (rd_ack_i) begin
          if (toggled_i) begin
            st_d = ST_IDLE; done_d = 1'b1; res_d[RES_ERR] = 1'b1;
          end else if (!erase_q && ver_q) begin
            st_d = ST_VERIFY;
          end else begin
            st_d = ST_IDLE; done_d = 1'b1; res_d[RES_PASS] = 1'b1;
          end
        end
      end
      ST_VERIFY: begin
        if (rd_ack_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          if (rd_data_i == exp_q) res_d[RES_PASS] = 1'b1;
          else                    res_d[RES_VER]  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      exp_q   <= '0;
      erase_q <= 1'b0;
      ver_q   <= 1'b0;
      lim_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      res_q  <= res_d;
      if (accept) begin
        addr_q  <= addr_d;
        exp_q   <= exp_d;
        erase_q <= erase_d;
        ver_q   <= ver_d;
        lim_q   <= lim_d;
      end
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign rd_req_o  = busy_o;
  assign rd_addr_o = addr_q;
  assign done_o    = done_q;
  assign res_o     = res_q;
  assign wd_lim_o  = lim_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(res_o) == 1 && !busy_o));
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(res_o));
  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(rd_addr_o));
  // R6
  err_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_o[RES_ERR]) |-> $past(st_q == ST_RECHK));
  // R7
  ver_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_o[RES_VER]) |-> $past(st_q == ST_VERIFY && !erase_q));
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpoll_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        exp_data_i,
  input  logic              erase_i,
  input  logic              verify_en_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_error_o,
  output logic              fail_verify_o,
  output logic              fail_watchdog_o
);
  logic             cap, toggled, wd_clr, wd_inc, wd_last;
  logic [CNT_W-1:0] wd_lim;
  logic [RES_N-1:0] res;

  tpoll_seq #(.AW(ADDR_W), .CW(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .exp_i(exp_data_i), .erase_i(erase_i), .ver_i(verify_en_i),
    .max_i(max_polls_i), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .toggled_i(toggled), .wd_last_i(wd_last), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .busy_o(busy_o), .done_o(done_o),
    .res_o(res), .cap_o(cap), .wd_clr_o(wd_clr), .wd_inc_o(wd_inc),
    .wd_lim_o(wd_lim)
  );

  tpoll_toggle #(.DW(DATA_W), .BIT(TOG_BIT)) tog_i (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .data_i(rd_data_i),
    .toggled_o(toggled)
  );

  tpoll_wdog #(.CW(CNT_W)) wdog_i (
    .clk(clk), .rst_n(rst_n), .clr_i(wd_clr), .inc_i(wd_inc),
    .lim_i(wd_lim), .last_o(wd_last)
  );

  assign pass_o          = res[RES_PASS];
  assign fail_error_o    = res[RES_ERR];
  assign fail_verify_o   = res[RES_VER];
  assign fail_watchdog_o = res[RES_WDG];

  // R2
  req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);
endmodule

// File: tb/toggle_poll_ctrl_tb.sv
module toggle_poll_ctrl_tb_top;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk, rst_n, start, erase, ver, rd_ack, rd_req, busy, done;
  logic pass, ferr, fver, fwdg;
  logic [AW-1:0] addr, rd_addr;
  logic [7:0] expd, rd_data;
  logic [CW-1:0] maxp;

  int checks = 0, fails = 0;
  int ridx = 0;
  logic [7:0] resp [8];

  toggle_poll_ctrl #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .exp_data_i(expd), .erase_i(erase), .verify_en_i(ver),
    .max_polls_i(maxp), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_ack_i(rd_ack), .rd_data_i(rd_data), .busy_o(busy), .done_o(done),
    .pass_o(pass), .fail_error_o(ferr), .fail_verify_o(fver),
    .fail_watchdog_o(fwdg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // codes: 0 pass, 1 error, 2 verify, 3 watchdog
  typedef struct packed {
    logic        erase;
    logic        ver;
    logic [7:0]  maxp;
    logic [7:0]  nrd;
    logic [63:0] bytes;   // first read in bits 7:0
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'd20, 8'd2, 64'h0000_0000_0000_0000, 2'd0}, // R3 erase settles
    '{1'b1, 1'b0, 8'd20, 8'd5, 64'h0000_0000_0040_0040, 2'd0}, // R4 toggles then settles
    '{1'b1, 1'b0, 8'd20, 8'd3, 64'h0000_0000_0060_6000, 2'd0}, // R5 confirm settles
    '{1'b1, 1'b0, 8'd20, 8'd3, 64'h0000_0000_0020_6000, 2'd1}, // R6 confirm still toggles
    '{1'b0, 1'b1, 8'd20, 8'd3, 64'h0000_0000_00A5_0000, 2'd0}, // R7 verify match
    '{1'b0, 1'b1, 8'd20, 8'd3, 64'h0000_0000_00A4_0000, 2'd2}, // R7 verify mismatch
    '{1'b0, 1'b0, 8'd20, 8'd2, 64'h0000_0000_0000_0000, 2'd0}, // R8 program no verify
    '{1'b0, 1'b1, 8'd3,  8'd4, 64'h0000_0000_4000_4000, 2'd3}, // R9 limit 3
    '{1'b0, 1'b1, 8'd20, 8'd4, 64'h0000_0000_A520_2040, 2'd0}, // R5 then R7
    '{1'b1, 1'b0, 8'd20, 8'd2, 64'h0000_0000_0000_6040, 2'd0}, // R3 bit5 on settled read
    '{1'b1, 1'b0, 8'd0,  8'd2, 64'h0000_0000_0000_4000, 2'd3}  // R9 limit 0
  };

  // read responder: one acknowledge per request, every other cycle
  initial begin
    rd_ack = 1'b0;
    rd_data = 8'h00;
    forever begin
      @(negedge clk);
      if (rd_ack) rd_ack = 1'b0;
      else if (rd_req) begin
        rd_data = (ridx < 8) ? resp[ridx] : (ridx[0] ? 8'h40 : 8'h00);
        rd_ack = 1'b1;
        ridx++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int flags();
    return {28'd0, fwdg, fver, ferr, pass};
  endfunction

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic launch(input logic e, input logic v, input logic [7:0] m,
                        input logic [63:0] b, input logic [AW-1:0] a);
    for (int i = 0; i < 8; i++) resp[i] = b[8*i +: 8];
    @(negedge clk);
    ridx = 0;
    erase = e; ver = v; maxp = m; addr = a; expd = 8'hA5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit seen;
    int fl;
    start = 1'b0; erase = 1'b0; ver = 1'b0; maxp = '0; addr = '0; expd = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check({busy, done, rd_req, pass, ferr, fver, fwdg} == 7'd0, "R1 in reset",
          int'({busy, done, rd_req, pass, ferr, fver, fwdg}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({busy, done, rd_req, pass, ferr, fver, fwdg} == 7'd0, "R1 after reset",
          int'({busy, done, rd_req, pass, ferr, fver, fwdg}), 0);

    for (int v = 0; v < NV; v++) begin
      launch(VECS[v].erase, VECS[v].ver, VECS[v].maxp, VECS[v].bytes, AW'(16'h1200 + v));
      // R2 latched address presented on reads
      check(busy && rd_addr == AW'(16'h1200 + v), "R2 address", int'(rd_addr), 16'h1200 + v);
      wait_done(seen);
      check(seen, "R10 done seen", int'(seen), 1);
      fl = flags();
      check(fl == (1 << VECS[v].code), $sformatf("R3-table vec %0d result", v),
            fl, 1 << VECS[v].code);
      check(ridx == int'(VECS[v].nrd), $sformatf("R8 vec %0d read count", v),
            ridx, int'(VECS[v].nrd));
      @(negedge clk);
      // R10 one-cycle pulse, flags held
      check(!done && flags() == fl && !busy, "R10 pulse/hold", int'(done), 0);
    end

    // R11: start pulses while busy are ignored
    launch(1'b1, 1'b0, 8'd20, 64'h4000_4000_4000_4000, AW'(16'h0777));
    repeat (5) @(negedge clk);
    addr = AW'(16'h0BAD);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(rd_addr == AW'(16'h0777), "R11 address kept", int'(rd_addr), 16'h0777);
    wait_done(seen);
    check(fwdg && seen, "R11 R9 run result", flags(), 8);
    check(ridx == 21, "R11 R9 read count", ridx, 21);

    // R10 flags cleared on next accepted start
    launch(1'b1, 1'b0, 8'd20, 64'h0, AW'(16'h0001));
    check(flags() == 0 && busy, "R10 clear on start", flags(), 0);
    wait_done(seen);
    check(pass, "R3 pass after clear", flags(), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule